// File: doc/BRIEF.md
# Pulse-Width Qualified Trigger Generator

This block watches one asynchronous, PWM-style input and raises a trigger output when the input has stayed high for a programmed number of sample ticks. A down-counter is preset to the threshold. It decrements on each sample tick, but only while the synchronized input is high and the block is armed. When the count is used up, the block emits a single-cycle terminal strobe. A one-shot stretches that strobe into an output pulse whose length is programmed in clock cycles. The trigger fires in the middle of a long enough pulse and does not wait for the falling edge. A falling edge presets the counter again, so high time never carries over from one pulse to the next.

After one trigger the block locks out and ignores the input until software pulses the arm input again. If software re-arms while the input is already high, the block does not count what is left of that pulse. Counting starts only at the next rising edge. A two-bit status output lets software poll whether the block is idle, armed or fired.

Top module: `pwq_trigger`

## Requirements
- R1: The input passes through a two-flop synchronizer, and edges are found by comparing the synchronized sample with the one before it. With a tick on every cycle, an input that goes high just before clock edge k makes the trigger output high from the clock edge k+T+1 onward, where T is the threshold.
- R2: After reset the status is 2'b00 (idle) and the trigger is low. An arm pulse sets the status to 2'b01 (armed). A trigger sets the status to 2'b10 (fired).
- R3: The counter only moves on cycles where the tick enable is high. An input pulse with no ticks during it produces no trigger.
- R4: While armed, a pulse fires the trigger once the ticks counted during its high time reach the threshold T. A threshold of 0 acts as 1. A pulse with fewer ticks than T produces no trigger. Repeated pulses of 3 cycles high and 9 low against T=10 never fire.
- R5: A falling edge of the synchronized input presets the counter to the threshold. Sub-threshold pulses therefore never add up to a trigger.
- R6: The trigger output stays high for exactly W clock cycles, where W is the width setting. A width of 0 acts as 1.
- R7: After a trigger, further input pulses are ignored and the status stays 2'b10 until the next arm pulse.
- R8: An arm pulse that arrives while the input is high does not count the rest of that pulse. Only a rising edge seen after the arm pulse starts counting.
- R9: While idle (never armed since reset), input pulses produce no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Sample tick enable for the high-time counter |
| pwmIn | input | 1 | Asynchronous PWM input |
| threshold | input | CNT_W | High-time threshold in ticks |
| pulseWidth | input | WID_W | Trigger output width in clock cycles |
| armStrobe | input | 1 | One-cycle re-arm request |
| trigOut | output | 1 | Qualified trigger pulse |
| status | output | 2 | 00 idle, 01 armed, 10 fired |

## Verification
On every cycle, the assertions check the following:
- The counter holds whenever it is neither preset nor stepped.
- A preset always loads the threshold.
- A terminal strobe only occurs in an armed state, and never before a rising edge after arming.
- A strobe always drives the trigger high on the next cycle.
- The fired state holds until an arm pulse.

Some behaviours can only be shown by the bench's pulse scenarios:
- The exact cycle at which the trigger rises relative to the input.
- The pulse width.
- Rejection of short pulses with no carry-over between them.
- The lockout across later pulses.
- The refusal to count a pulse already in progress when the block is re-armed.

// File: rtl/pwq_pkg.sv
package pwq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } ctlState_e;

  typedef struct packed {
    logic load;
    logic dec;
  } cntCtl_t;

  localparam logic [1:0] STAT_IDLE  = 2'b00;
  localparam logic [1:0] STAT_ARMED = 2'b01;
  localparam logic [1:0] STAT_FIRED = 2'b10;
endpackage

// File: rtl/pwq_edge_sync.sv
module pwq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic prevLevel;

  generate
    if (STAGES < 2) begin : g_badStages
      initial $error("pwq_edge_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain     <= '0;
      prevLevel <= 1'b0;
    end else begin
      chain     <= {chain[STAGES-2:0], asyncIn};
      prevLevel <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prevLevel;
  assign fall  = ~level & prevLevel;
endmodule

// File: rtl/pwq_ctrl.sv
module pwq_ctrl
  import pwq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armStrobe,
  input  logic       tickEn,
  input  logic       level,
  input  logic       rise,
  input  logic       fall,
  input  logic       tc,
  output cntCtl_t    ctl,
  output logic [1:0] status
);
  ctlState_e state, stateNext;
  logic active;

  always_comb begin
    active   = (state == ST_COUNT) | ((state == ST_WAIT) & rise);
    ctl.dec  = active & level & tickEn & ~armStrobe;
    ctl.load = armStrobe | fall | ~active;
  end

  always_comb begin
    stateNext = state;
    if (armStrobe) begin
      stateNext = ST_WAIT;
    end else if (tc) begin
      stateNext = ST_DONE;
    end else begin
      unique case (state)
        ST_IDLE:  stateNext = ST_IDLE;
        ST_WAIT:  if (rise) stateNext = ST_COUNT;
        ST_COUNT: if (fall) stateNext = ST_WAIT;
        ST_DONE:  stateNext = ST_DONE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    unique case (state)
      ST_WAIT, ST_COUNT: status = STAT_ARMED;
      ST_DONE:           status = STAT_FIRED;
      default:           status = STAT_IDLE;
    endcase
  end

  // R4 / R9: a terminal strobe only happens while armed
  assert_fire_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (state == ST_WAIT || state == ST_COUNT));

  // R8: no strobe while waiting for a fresh rising edge
  assert_no_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !rise) |-> !tc);

  // R7: lockout persists until re-armed
  assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !armStrobe) |=> (status == STAT_FIRED));
endmodule

// File: rtl/pwq_datapath.sv
module pwq_datapath
  import pwq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cntCtl_t          ctl,
  input  logic [CNT_W-1:0] threshold,
  input  logic [WID_W-1:0] pulseWidth,
  output logic             tc,
  output logic             trigOut
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [WID_W-1:0] WID_ONE = WID_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [WID_W-1:0] widthLeft;
  logic [WID_W-1:0] widthLoad;

  assign tc        = ctl.dec & (cnt <= CNT_ONE);
  assign widthLoad = (pulseWidth == '0) ? WID_ONE : pulseWidth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= threshold;
    end else if (ctl.dec) begin
      cnt <= (cnt == '0) ? '0 : cnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widthLeft <= '0;
    end else if (tc) begin
      widthLeft <= widthLoad;
    end else if (widthLeft != '0) begin
      widthLeft <= widthLeft - WID_ONE;
    end
  end

  assign trigOut = (widthLeft != '0);

  // R3: the count moves only when stepped or preset
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load && !ctl.dec) |=> $stable(cnt));

  // R5: a preset always takes the threshold
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (cnt == $past(threshold)));

  // R6: a strobe always starts the output pulse
  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> trigOut);
endmodule

// File: rtl/pwq_trigger.sv
module pwq_trigger
  import pwq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WID_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             pwmIn,
  input  logic [CNT_W-1:0] threshold,
  input  logic [WID_W-1:0] pulseWidth,
  input  logic             armStrobe,
  output logic             trigOut,
  output logic [1:0]       status
);
  logic    level, rise, fall, tc;
  cntCtl_t ctl;

  pwq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(pwmIn),
    .level(level), .rise(rise), .fall(fall)
  );

  pwq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .armStrobe(armStrobe), .tickEn(tickEn),
    .level(level), .rise(rise), .fall(fall), .tc(tc),
    .ctl(ctl), .status(status)
  );

  pwq_datapath #(.CNT_W(CNT_W), .WID_W(WID_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .threshold(threshold),
    .pulseWidth(pulseWidth), .tc(tc), .trigOut(trigOut)
  );
endmodule

// File: tb/tb_pwq_trigger.sv
`timescale 1ns/1ps
module tb_pwq_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b1;
  logic        pwmIn = 1'b0;
  logic [15:0] threshold = 16'd10;
  logic [7:0]  pulseWidth = 8'd4;
  logic        armStrobe = 1'b0;
  logic        trigOut;
  logic [1:0]  status;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  int firstIdx;
  int highCnt;

  always #4 clk = ~clk;

  pwq_trigger dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .pwmIn(pwmIn),
    .threshold(threshold), .pulseWidth(pulseWidth), .armStrobe(armStrobe),
    .trigOut(trigOut), .status(status)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d exp<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int effT(int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int effW(int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic bit expFire(bit armed, bit ticks, int hi, int t);
    return armed && ticks && (hi >= effT(t));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic arm();
    @(negedge clk) armStrobe = 1'b1;
    @(negedge clk) armStrobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Drives hi cycles high then lo cycles low; measures trigOut.
  task automatic runPulse(int hi, int lo);
    firstIdx = -1;
    highCnt = 0;
    for (int i = 0; i < hi + lo; i++) begin
      @(negedge clk);
      if (trigOut) begin
        if (firstIdx < 0) firstIdx = i;
        highCnt = highCnt + 1;
      end
      pwmIn = (i < hi);
    end
  endtask

  task automatic checkPulse(string req, bit expF, int t, int w);
    if (expF) begin
      chk(firstIdx == effT(t) + 2, req, "trigger start index", firstIdx, effT(t) + 2);
      chk(highCnt == effW(w), req, "trigger width", highCnt, effW(w));
    end else begin
      chk(highCnt == 0, req, "no trigger expected", highCnt, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(status == 2'b00, "R2", "reset status", status, 0);
    chk(trigOut == 1'b0, "R2", "reset trigger", trigOut, 0);

    // R9 idle ignores pulses
    threshold = 16'd5; pulseWidth = 8'd3;
    runPulse(30, 20);
    checkPulse("R9", 0, 5, 3);
    chk(status == 2'b00, "R9", "status still idle", status, 0);

    // R2 arm -> armed
    arm();
    chk(status == 2'b01, "R2", "status after arm", status, 1);

    // R4 exact threshold fires (R1 latency via start index)
    threshold = 16'd10; pulseWidth = 8'd4;
    runPulse(10, 30);
    checkPulse("R1", 1, 10, 4);
    chk(status == 2'b10, "R2", "status after fire", status, 2);

    // R7 lockout
    runPulse(40, 30);
    checkPulse("R7", 0, 10, 4);
    chk(status == 2'b10, "R7", "status stays fired", status, 2);

    // R4 one short of threshold
    arm();
    runPulse(9, 30);
    checkPulse("R4", 0, 10, 4);

    // R4 short pulse train 3 high / 9 low, R5 no accumulation
    for (int k = 0; k < 6; k++) runPulse(3, 9);
    chk(highCnt == 0, "R4", "3/9 train no trigger", highCnt, 0);
    chk(status == 2'b01, "R4", "still armed after 3/9 train", status, 1);
    for (int k = 0; k < 5; k++) begin
      runPulse(9, 9);
      chk(highCnt == 0, "R5", "sub-threshold pulse no carry", highCnt, 0);
    end

    // R3 no ticks -> no fire
    tickEn = 1'b0;
    runPulse(40, 20);
    checkPulse("R3", 0, 10, 4);
    chk(status == 2'b01, "R3", "armed with no ticks", status, 1);
    tickEn = 1'b1;

    // R8 arm while input high
    arm();
    runPulse(3, 0);   // input now high
    arm();            // re-arm mid-pulse
    runPulse(40, 20);
    checkPulse("R8", 0, 10, 4);
    chk(status == 2'b01, "R8", "armed after partial pulse", status, 1);
    runPulse(12, 30);
    checkPulse("R8", 1, 10, 4);

    // R4 threshold 0, R6 width 0
    threshold = 16'd0; pulseWidth = 8'd0;
    arm();
    runPulse(1, 20);
    checkPulse("R6", 1, 0, 0);

    // Random mix
    for (int n = 0; n < 40; n++) begin
      int t, w, h;
      bit e;
      t = $urandom_range(1, 30);
      w = $urandom_range(0, 15);
      h = $urandom_range(1, 40);
      threshold = 16'(t); pulseWidth = 8'(w);
      arm();
      runPulse(h, t + w + 12);
      e = expFire(1, 1, h, t);
      checkPulse(e ? "R6" : "R4", e, t, w);
      chk(status == (e ? 2'b10 : 2'b01), "R7", "status after random pulse",
          status, e ? 2 : 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule